// File: doc/BRIEF.md
# Sequential Parallel-Bus Configuration Loader

The loader takes configuration bytes from an upstream valid/ready byte stream and writes them to as many as four target devices, one device at a time, over one shared 8-bit slave configuration bus. The clock, the data byte and the active-low write strobe go to every target. Each target has its own active-low chip select, so only the device that holds the bus sees the writes. Two slave-parallel target families that differ only in pin naming use the same logic.

A host sets the number of targets and a byte count for each one, then pulses `start`. The block captures these settings and selects target 0. It writes that target's bytes, waits out a quiet gap with every select released, and moves on to the next target. `done` reports the end of the run. The configuration clock comes from the system clock through a parameterised divider. With the defaults (divide by eight from 125 MHz) it runs at about 15.6 MHz, which stays under the 19 MHz limit of the targets and gives at most one byte per configuration clock. When the stream has no byte ready, the configuration clock stops low and waits.

Top module: `pbus_loader`

## Requirements
- R1: Reset, asynchronous and active low, and also the idle state, hold every `cfg_cs_n` bit high, `cfg_wr_n` high and `cfg_clk` low, with `busy`, `done`, `error` and `src_ready` low.
- R2: A `start` with `tgt_count` from 1 to 4 writes targets 0 up to `tgt_count`-1 in that order. Target i takes its byte count from `byte_counts[i*16 +: 16]`. Each byte appears on `cfg_data` at a rising edge of `cfg_clk` while only `cfg_cs_n[i]` is low, and the bytes keep the order of the stream.
- R3: At most one `cfg_cs_n` bit is low at a time, and `cfg_wr_n` is low exactly while one of them is low.
- R4: `cfg_data` and `cfg_cs_n` stay unchanged while `cfg_clk` is high. Each high phase of `cfg_clk` lasts exactly CLK_DIV system clocks.
- R5: There is exactly one `cfg_clk` rising edge for each byte taken (`src_valid` and `src_ready` both high). `src_ready` is high only when `src_valid` is high. While `src_valid` stays low, `cfg_clk` stays low once any byte already taken has been clocked out.
- R6: Between the release of one target's select and the assertion of the next target's select there are at least 2*2*CLK_DIV system clocks, which is two configuration clock periods.
- R7: A `start` with `tgt_count` equal to 0 or above 4 raises `error` for exactly one cycle. The bus is not touched and `busy` stays low.
- R8: `done` is high for exactly one system clock. That clock is the first one in which the last target's select is high again, and `busy` is low in the same clock.
- R9: A target whose byte count is zero is skipped, and its select never asserts.
- R10: A `start` while `busy` is high is ignored. The settings captured at the start of the run stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command to begin a run |
| tgt_count | input | 3 | Number of targets to load (valid range 1 to 4) |
| byte_counts | input | 64 | Byte count per target, 16 bits each, target i in bits i*16 and up |
| src_data | input | 8 | Byte from the upstream source |
| src_valid | input | 1 | Upstream byte is valid |
| src_ready | output | 1 | Byte taken in this cycle |
| cfg_clk | output | 1 | Configuration clock; targets sample on its rising edge |
| cfg_data | output | 8 | Shared configuration data byte |
| cfg_wr_n | output | 1 | Active-low write strobe |
| cfg_cs_n | output | 4 | Active-low chip select, one per target |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | One-cycle pulse for a rejected target count |

## Verification
A wrong byte counter or target index shows at the next rising edge of `cfg_clk`: a byte goes to the wrong select line, arrives out of stream order, or the number of rising edges per target no longer matches the programmed count. A divider or phase fault shows within one configuration period as a high phase of the wrong length, or as data or a select that moves while the clock is high. A wrong sequencer state shows in the following ways: two selects low at once, a select that asserts for a target with a zero count, a gap shorter than two configuration clocks, or `done` pulsing early, twice or never. The bench measures each of these at the pins across a sweep of every target count and of several byte-count and stream-stall patterns.

// File: rtl/pbus_loader.sv
module pbus_loader #(
  parameter int MAX_TGT  = 4,
  parameter int CNT_W    = 16,
  parameter int CLK_DIV  = 4,
  parameter int GAP_CLKS = 2,
  localparam int TC_W    = $clog2(MAX_TGT) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TC_W-1:0]          tgt_count,
  input  logic [MAX_TGT*CNT_W-1:0] byte_counts,
  input  logic [7:0]               src_data,
  input  logic                     src_valid,
  output logic                     src_ready,
  output logic                     cfg_clk,
  output logic [7:0]               cfg_data,
  output logic                     cfg_wr_n,
  output logic [MAX_TGT-1:0]       cfg_cs_n,
  output logic                     busy,
  output logic                     done,
  output logic                     error
);

  localparam int IDX_W   = (MAX_TGT > 1) ? $clog2(MAX_TGT) : 1;
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int GAP_CYC = GAP_CLKS * 2 * CLK_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_LOAD, S_GAP} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx, last_idx;
  logic [CNT_W-1:0] cnt_q [MAX_TGT];
  logic [CNT_W-1:0] remain;
  logic [DIV_W-1:0] div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic             clk_q, loaded, done_q, err_q;
  logic [7:0]       data_q;

  logic tick, bad_count, is_last, take, drained;

  assign tick      = (div_cnt == DIV_W'(CLK_DIV - 1));
  assign bad_count = (tgt_count == '0) || (tgt_count > TC_W'(MAX_TGT));
  assign is_last   = (idx == last_idx);
  assign take      = (st == S_LOAD) && !clk_q && !loaded && (remain != '0) && src_valid;
  assign drained   = (st == S_LOAD) && !clk_q && !loaded && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      last_idx <= '0;
      remain   <= '0;
      div_cnt  <= '0;
      gap_cnt  <= '0;
      clk_q    <= 1'b0;
      loaded   <= 1'b0;
      data_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      for (int i = 0; i < MAX_TGT; i++) cnt_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          div_cnt <= '0;
          if (start) begin
            if (bad_count) begin
              err_q <= 1'b1;
            end else begin
              last_idx <= IDX_W'(tgt_count - 1'b1);
              idx      <= '0;
              for (int i = 0; i < MAX_TGT; i++) cnt_q[i] <= byte_counts[i*CNT_W +: CNT_W];
              st       <= S_SEL;
            end
          end
        end
        S_SEL: begin
          if (cnt_q[idx] == '0) begin
            if (is_last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            remain  <= cnt_q[idx];
            div_cnt <= '0;
            st      <= S_LOAD;
          end
        end
        S_LOAD: begin
          div_cnt <= tick ? '0 : div_cnt + 1'b1;
          if (take) begin
            data_q <= src_data;
            loaded <= 1'b1;
            remain <= remain - 1'b1;
          end
          if (tick && clk_q) begin
            clk_q <= 1'b0;
          end else if (tick && loaded) begin
            clk_q  <= 1'b1;
            loaded <= 1'b0;
          end
          if (drained) begin
            div_cnt <= '0;
            if (is_last) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              gap_cnt <= '0;
              st      <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
            idx <= idx + 1'b1;
            st  <= S_SEL;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign src_ready = take;
  assign cfg_clk   = clk_q;
  assign cfg_data  = data_q;
  assign cfg_wr_n  = (st != S_LOAD);
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign error     = err_q;

  for (genvar g = 0; g < MAX_TGT; g++) begin : g_cs
    assign cfg_cs_n[g] = !((st == S_LOAD) && (idx == IDX_W'(g)));
  end

  p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cfg_cs_n && cfg_wr_n && !cfg_clk));

  p_single_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cfg_cs_n));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));

  p_cs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_cs_n));

  p_ready_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> src_valid);

  p_error_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && &cfg_cs_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && &cfg_cs_n));

endmodule

// File: tb/tb_pbus_loader.sv
module tb_pbus_loader;
  localparam int MAX_TGT = 4;
  localparam int CNT_W   = 16;
  localparam int CLK_DIV = 4;
  localparam int GAP_CYC = 2 * 2 * CLK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] tgt_count = '0;
  logic [MAX_TGT*CNT_W-1:0] byte_counts = '0;
  logic [7:0] src_data;
  logic src_valid;
  logic src_ready, cfg_clk, cfg_wr_n, busy, done, error;
  logic [7:0] cfg_data;
  logic [MAX_TGT-1:0] cfg_cs_n;

  always #4 clk = ~clk;

  pbus_loader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_count(tgt_count),
    .byte_counts(byte_counts), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .cfg_wr_n(cfg_wr_n), .cfg_cs_n(cfg_cs_n), .busy(busy), .done(done),
    .error(error)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // byte source
  int vmode = 0;
  int jcyc = 0;
  int jbase = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_data  <= 8'h00;
      src_valid <= 1'b0;
    end else begin
      int rel;
      rel = jcyc - jbase;
      jcyc <= jcyc + 1;
      if (src_valid && src_ready) src_data <= src_data + 8'd1;
      case (vmode)
        0: src_valid <= 1'b1;
        1: src_valid <= (rel % 3) != 0;
        2: src_valid <= (rel % 16) < 5;
        default: src_valid <= !(rel >= 30 && rel < 90);
      endcase
    end
  end

  // job settings, driven by the stimulus only
  int n = 0;
  int c [MAX_TGT];
  bit clr_req = 1'b0;

  // monitor state, driven by the monitor only
  int rx [MAX_TGT];
  int cs_act [MAX_TGT];
  int rises, daterr, tgterr, ovl, wrerr, stab, hierr, hi_len, gaperr, gapc;
  int hs, vlow, stallerr, donec, donebad, errc, busyc, csany, clkhi;
  bit had_cs, prev_clk;
  logic [MAX_TGT-1:0] prev_cs;
  logic [7:0] prev_data, exp_data;

  function automatic int exp_tgt();
    for (int i = 0; i < n; i++) if (rx[i] < c[i]) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (clr_req) begin
      for (int i = 0; i < MAX_TGT; i++) begin rx[i] = 0; cs_act[i] = 0; end
      rises = 0; daterr = 0; tgterr = 0; ovl = 0; wrerr = 0; stab = 0; hierr = 0;
      hi_len = 0; gaperr = 0; gapc = 0; hs = 0; vlow = 0; stallerr = 0; donec = 0;
      donebad = 0; errc = 0; busyc = 0; csany = 0; clkhi = 0; had_cs = 0;
      prev_clk = cfg_clk; prev_cs = cfg_cs_n; prev_data = cfg_data; exp_data = src_data;
    end else if (rst_n) begin
      int t;
      if (!$onehot0(~cfg_cs_n)) ovl++;
      if (cfg_wr_n != &cfg_cs_n) wrerr++;
      if (cfg_clk && prev_clk && (cfg_data != prev_data || cfg_cs_n != prev_cs)) stab++;
      if (cfg_clk) hi_len++;
      else if (prev_clk) begin
        if (hi_len != CLK_DIV) hierr++;
        hi_len = 0;
      end
      if (cfg_clk && !prev_clk) begin
        rises++;
        t = exp_tgt();
        if (t < 0 || cfg_cs_n != ~(4'b0001 << t)) tgterr++;
        if (cfg_data != exp_data) daterr++;
        exp_data = exp_data + 8'd1;
        if (t >= 0) rx[t]++;
      end
      if (&cfg_cs_n) gapc++;
      else begin
        if (&prev_cs) begin
          if (had_cs && gapc < GAP_CYC) gaperr++;
          had_cs = 1;
          for (int i = 0; i < MAX_TGT; i++) if (!cfg_cs_n[i]) cs_act[i]++;
        end
        gapc = 0;
      end
      if (src_valid && src_ready) hs++;
      if (!src_valid) vlow++; else vlow = 0;
      if (vlow > 2 * CLK_DIV + 2 && cfg_clk) stallerr++;
      if (done) begin
        donec++;
        if (!(&cfg_cs_n) || busy) donebad++;
      end
      if (error) errc++;
      if (busy) busyc++;
      if (!(&cfg_cs_n)) csany++;
      if (cfg_clk) clkhi++;
      prev_clk = cfg_clk; prev_cs = cfg_cs_n; prev_data = cfg_data;
    end
  end

  task automatic setup(input int nn, input int c0, input int c1, input int c2, input int c3, input int vm);
    @(posedge clk); #1;
    n = nn; c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3; vmode = vm; jbase = jcyc;
    tgt_count = 3'(nn);
    byte_counts = {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
    clr_req = 1'b1;
    @(negedge clk); #1;
    clr_req = 1'b0;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_job(input int nn, input int c0, input int c1, input int c2, input int c3,
                         input int vm, input bit poke);
    int total, to;
    setup(nn, c0, c1, c2, c3, vm);
    if (poke) begin
      repeat (20) @(posedge clk); #1;
      tgt_count = 3'd1; byte_counts = '1; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    to = 0;
    while (donec == 0 && to < 6000) begin @(negedge clk); to++; end
    repeat (3) @(negedge clk);
    total = 0;
    for (int i = 0; i < nn; i++) total += c[i];
    chk(rises == total, "R2 byte count", rises, total);
    chk(daterr == 0, "R2 stream order", daterr, 0);
    chk(tgterr == 0, "R2 target select", tgterr, 0);
    for (int i = 0; i < MAX_TGT; i++)
      chk(cs_act[i] == ((i < nn && c[i] > 0) ? 1 : 0), "R9 select asserts once or skipped",
          cs_act[i], (i < nn && c[i] > 0) ? 1 : 0);
    chk(ovl == 0 && wrerr == 0, "R3 one select with strobe", ovl + wrerr, 0);
    chk(stab == 0 && hierr == 0, "R4 stable high phase", stab + hierr, 0);
    chk(hs == rises, "R5 one edge per byte", hs, rises);
    chk(gaperr == 0, "R6 select gap", gaperr, 0);
    chk(donec == 1 && donebad == 0, "R8 done pulse", donec * 10 + donebad, 10);
    if (vm == 3) chk(stallerr == 0, "R5 clock held during stall", stallerr, 0);
    if (poke) chk(donec == 1 && rises == total, "R10 start while busy ignored", rises, total);
  endtask

  task automatic bad_job(input int cnt);
    setup(cnt, 1, 1, 1, 1, 0);
    repeat (20) @(negedge clk);
    chk(errc == 1, "R7 error pulse", errc, 1);
    chk(busyc == 0 && csany == 0 && clkhi == 0, "R7 bus untouched", busyc + csany + clkhi, 0);
  endtask

  task automatic check_parked(input string req);
    chk(&cfg_cs_n && cfg_wr_n && !cfg_clk, {req, " bus parked"},
        {cfg_cs_n, cfg_wr_n, cfg_clk}, 6'b111110);
    chk(!busy && !done && !error && !src_ready, {req, " status low"},
        {busy, done, error, src_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_parked("R1 reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_parked("R1 idle");

    for (int nn = 1; nn <= MAX_TGT; nn++)
      for (int vm = 0; vm < 3; vm++)
        run_job(nn, (nn + vm) % 4, (nn + 2 + vm) % 4, (nn + 4 + vm) % 4, (nn + 6 + vm) % 4, vm, 1'b0);

    run_job(4, 2, 0, 0, 3, 0, 1'b0);
    run_job(3, 0, 0, 0, 0, 0, 1'b0);
    run_job(1, 1, 0, 0, 0, 1, 1'b0);
    run_job(2, 6, 6, 0, 0, 3, 1'b0);
    run_job(4, 5, 4, 3, 2, 0, 1'b1);

    bad_job(0);
    bad_job(5);
    bad_job(6);
    bad_job(7);

    setup(2, 8, 8, 0, 0, 0);
    repeat (40) @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check_parked("R1 reset mid-run");
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_parked("R1 idle after reset");

    run_job(4, 1, 2, 3, 1, 2, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule